// File: doc/BRIEF.md
# Parallel-Output Converter Host Sequencer

This block runs a successive-approximation converter with a parallel result bus from the host side. The block is fully synchronous. A start request makes it pull the active-low convert line down for a fixed number of clocks. It then follows the converter's busy flag through its rise and fall. After busy falls, it drives chip-select and read low in the same cycle, holds both for a set number of clocks, and captures the result bus. The captured result is shown on a zero-extended output word, marked by a one-cycle valid pulse.

When reset ends, the block starts one conversion by itself and throws its result away. The converter's first result after power-up cannot be trusted, so no valid pulse is given for that word. The busy input comes from another clock domain, so it is synchronized before use. Two watchdog windows cover the busy handshake: one waits for busy to rise, and one waits for it to fall. If either window runs out, the sequence is abandoned and a one-cycle error pulse is given.

Top module: `adc_host_ctrl`

## Requirements
- R1: `convst_n_o`, `cs_n_o` and `rd_n_o` are driven high while `rst_n` is low and whenever no conversion or read is in progress.
- R2: A start request (`start_i` high at a rising edge while the sequencer is idle and the throwaway conversion is finished) drives `convst_n_o` low from the next cycle for exactly CONV_LOW_CYC cycles (default 2).
- R3: After the convert pulse, the sequencer waits for the synchronized busy flag to go high. If it is not high within RISE_TMO cycles (default 16), `err_o` pulses high for one cycle, the sequencer goes back to idle, and no read is made.
- R4: The read phase starts only after a high-to-low transition of the synchronized busy flag. If busy stays high for FALL_TMO cycles (default 64), `err_o` pulses for one cycle and no read is made.
- R5: `cs_n_o` and `rd_n_o` fall in the same cycle, stay low for exactly RD_LOW_CYC cycles (default 2), and rise in the same cycle. They are never low while `convst_n_o` is low.
- R6: The word on `db_i` is captured in the last cycle of the read phase. `valid_o` is high for exactly one cycle, in the cycle where `cs_n_o` returns high. In that cycle and afterwards, `data_o` holds the captured word until the next capture.
- R7: `data_o` bits OUT_W-1 down to DATA_W are always zero (default DATA_W=12, OUT_W=16).
- R8: After reset is released, one full conversion runs without any start request: one convert pulse and one read. No `valid_o` pulse is given for it, and `data_o` stays zero.
- R9: Start requests that arrive while a conversion or read is in progress, including the throwaway conversion, are ignored. No extra convert pulse follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, sampled in idle only |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| db_i | input | DATA_W | Converter parallel result bus |
| convst_n_o | output | 1 | Active-low convert-start strobe |
| cs_n_o | output | 1 | Active-low chip-select |
| rd_n_o | output | 1 | Active-low read strobe |
| valid_o | output | 1 | One-cycle pulse marking a new result |
| data_o | output | OUT_W | Zero-extended conversion result |
| err_o | output | 1 | One-cycle pulse on a busy timeout |

## Verification
Every cycle, the assertions check these properties:
- The convert and read strobes never overlap.
- Chip-select and read always move together.
- A read only begins once synchronized busy is low.
- The valid and error pulses last a single cycle, and valid lines up with chip-select being released.

Only the bench scenarios can show these behaviours:
- The exact lengths of the convert and read pulses.
- The capture of the word on the final read cycle rather than the first.
- The silent throwaway conversion after reset.
- Start requests being dropped while the sequencer is busy.
- The behaviour of both timeout windows against a converter that never answers or never finishes.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CONV  = 3'd1,
    PH_WRISE = 3'd2,
    PH_WFALL = 3'd3,
    PH_READ  = 3'd4
  } phase_e;
endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  output logic busy_s,
  output logic busy_fell
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= busy_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign busy_s    = sync_q;
  assign busy_fell = prev_q & ~sync_q;
endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              keep,
  input  logic [DATA_W-1:0] db_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              valid_o
);
  logic [OUT_W-1:0] data_q;
  logic             valid_q;
  logic             upd_en;

  assign upd_en = cap_en & keep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= upd_en;
      if (upd_en) data_q <= OUT_W'(db_i);
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl #(
  parameter int DATA_W       = 12,
  parameter int OUT_W        = 16,
  parameter int CONV_LOW_CYC = 2,
  parameter int RD_LOW_CYC   = 2,
  parameter int RISE_TMO     = 16,
  parameter int FALL_TMO     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] db_i,
  output logic              convst_n_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              valid_o,
  output logic [OUT_W-1:0]  data_o,
  output logic              err_o
);
  import adc_host_pkg::*;

  localparam int MAX_A  = (CONV_LOW_CYC > RD_LOW_CYC) ? CONV_LOW_CYC : RD_LOW_CYC;
  localparam int MAX_B  = (RISE_TMO > FALL_TMO) ? RISE_TMO : FALL_TMO;
  localparam int MAX_LD = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W  = $clog2(MAX_LD + 1);
  localparam logic [TMR_W-1:0] LD_CONV = TMR_W'(CONV_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_READ = TMR_W'(RD_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RISE = TMR_W'(RISE_TMO - 1);
  localparam logic [TMR_W-1:0] LD_FALL = TMR_W'(FALL_TMO - 1);

  phase_e            state_q, state_d;
  logic              dummy_q, dummy_d;
  logic              err_q, err_d;
  logic              convst_n_q, strobe_n_q;
  logic              tmr_load, tmr_exp, cap_en;
  logic [TMR_W-1:0]  tmr_val;
  logic              busy_s, busy_fell;

  adc_busy_sync u_sync (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
    .busy_s(busy_s), .busy_fell(busy_fell)
  );

  adc_phase_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .load_val(tmr_val), .expired(tmr_exp)
  );

  adc_word_capture #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .keep(~dummy_q),
    .db_i(db_i), .data_o(data_o), .valid_o(valid_o)
  );

  always_comb begin
    state_d  = state_q;
    dummy_d  = dummy_q;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (dummy_q || start_i) begin
          state_d  = PH_CONV;
          tmr_load = 1'b1;
          tmr_val  = LD_CONV;
        end
      end
      PH_CONV: begin
        if (tmr_exp) begin
          state_d  = PH_WRISE;
          tmr_load = 1'b1;
          tmr_val  = LD_RISE;
        end
      end
      PH_WRISE: begin
        if (busy_s) begin
          state_d  = PH_WFALL;
          tmr_load = 1'b1;
          tmr_val  = LD_FALL;
        end else if (tmr_exp) begin
          state_d = PH_IDLE;
          err_d   = 1'b1;
        end
      end
      PH_WFALL: begin
        if (busy_fell) begin
          state_d  = PH_READ;
          tmr_load = 1'b1;
          tmr_val  = LD_READ;
        end else if (tmr_exp) begin
          state_d = PH_IDLE;
          err_d   = 1'b1;
        end
      end
      PH_READ: begin
        if (tmr_exp) begin
          state_d = PH_IDLE;
          cap_en  = 1'b1;
          dummy_d = 1'b0;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PH_IDLE;
      dummy_q    <= 1'b1;
      err_q      <= 1'b0;
      convst_n_q <= 1'b1;
      strobe_n_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      dummy_q    <= dummy_d;
      err_q      <= err_d;
      convst_n_q <= (state_d != PH_CONV);
      strobe_n_q <= (state_d != PH_READ);
    end
  end

  assign convst_n_o = convst_n_q;
  assign cs_n_o     = strobe_n_q;
  assign rd_n_o     = strobe_n_q;
  assign err_o      = err_q;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!convst_n_o && !cs_n_o));

  // R4
  read_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> !busy_s);

  // R6
  valid_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));

  // R3
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !err_o);

  // R5
  pair_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> $fell(rd_n_o));
endmodule

// File: tb/adc_host_ctrl_bench.sv
`timescale 1ns/1ps
module adc_host_ctrl_bench;
  localparam int DW = 12;
  localparam int OW = 16;

  logic          clk, rst_n, start, busy;
  logic [DW-1:0] db;
  logic          convst_n, cs_n, rd_n, valid, err;
  logic [OW-1:0] data;

  int errors = 0, checks = 0;
  logic done = 1'b0;

  logic          model_en = 1'b1;
  int            rise_dly = 1;
  int            conv_len = 20;
  logic [DW-1:0] sample_val = '0;
  int            rd_cyc = 0;

  int conv_pulses = 0, conv_run = 0, last_conv_len = 0;
  int cs_pulses = 0, cs_run = 0, last_cs_len = 0;
  int valid_cnt = 0, err_cnt = 0, pair_mismatch = 0;
  logic [OW-1:0] last_data = '0;

  adc_host_ctrl #(.DATA_W(DW), .OUT_W(OW)) u_adc_host_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_i(busy), .db_i(db),
    .convst_n_o(convst_n), .cs_n_o(cs_n), .rd_n_o(rd_n),
    .valid_o(valid), .data_o(data), .err_o(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!cs_n) rd_cyc <= rd_cyc + 1;
    else       rd_cyc <= 0;
  end
  assign db = (!cs_n && !rd_n) ? ((rd_cyc == 0) ? 12'h3C3 : sample_val) : 12'hAAA;

  initial begin
    busy = 1'b0;
    forever begin
      @(negedge convst_n);
      if (model_en) begin
        repeat (rise_dly) @(negedge clk);
        busy = 1'b1;
        repeat (conv_len) @(negedge clk);
        busy = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!convst_n) conv_run++;
      else if (conv_run > 0) begin last_conv_len = conv_run; conv_pulses++; conv_run = 0; end
      if (!cs_n) cs_run++;
      else if (cs_run > 0) begin last_cs_len = cs_run; cs_pulses++; cs_run = 0; end
      if (cs_n != rd_n) pair_mismatch++;
      if (valid) begin valid_cnt++; last_data = data; end
      if (err) err_cnt++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end(input int v0, input int e0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (valid_cnt != v0 || err_cnt != e0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    start = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", convst_n, 1, "convst_n in reset");
    chk("R1", cs_n, 1, "cs_n in reset");
    chk("R1", rd_n, 1, "rd_n in reset");
    chk("R6", valid, 0, "valid in reset");
    chk("R3", err, 0, "err in reset");
  endtask

  task automatic test_dummy();
    sample_val = 12'h5A5;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    pulse_start();
    repeat (120) @(negedge clk);
    chk("R8", conv_pulses, 1, "throwaway convert pulses");
    chk("R8", cs_pulses, 1, "throwaway reads");
    chk("R8", valid_cnt, 0, "valid after throwaway");
    chk("R8", data, 0, "data after throwaway");
    chk("R9", conv_pulses, 1, "start during throwaway ignored");
    chk("R1", convst_n & cs_n, 1, "strobes high in idle");
  endtask

  task automatic test_normal(input logic [DW-1:0] val, input int rdly);
    int v0 = valid_cnt, e0 = err_cnt, c0 = conv_pulses;
    sample_val = val; rise_dly = rdly;
    pulse_start();
    wait_end(v0, e0);
    chk("R2", conv_pulses - c0, 1, "one convert pulse");
    chk("R2", last_conv_len, 2, "convert pulse length");
    chk("R5", last_cs_len, 2, "read strobe length");
    chk("R5", pair_mismatch, 0, "cs/rd mismatch cycles");
    chk("R6", valid_cnt - v0, 1, "valid pulses");
    chk("R6", last_data, OW'(val), "captured word (last read cycle)");
    chk("R6", data, OW'(val), "data held after valid");
    chk("R7", data[OW-1:DW], 0, "upper bits zero");
    chk("R4", err_cnt - e0, 0, "no error on good conversion");
  endtask

  task automatic test_ignore();
    int c0 = conv_pulses, v0 = valid_cnt;
    sample_val = 12'h1E7; rise_dly = 1;
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (120) @(negedge clk);
    chk("R9", conv_pulses - c0, 1, "starts while busy ignored");
    chk("R9", valid_cnt - v0, 1, "single result");
  endtask

  task automatic test_rise_timeout();
    int e0 = err_cnt, v0 = valid_cnt, s0 = cs_pulses;
    model_en = 1'b0;
    pulse_start();
    wait_end(v0, e0);
    chk("R3", err_cnt - e0, 1, "rise timeout error pulse");
    chk("R3", cs_pulses - s0, 0, "no read after rise timeout");
    chk("R3", valid_cnt - v0, 0, "no valid after rise timeout");
    model_en = 1'b1;
  endtask

  task automatic test_fall_timeout();
    int e0 = err_cnt, v0 = valid_cnt, s0 = cs_pulses;
    conv_len = 200;
    pulse_start();
    wait_end(v0, e0);
    chk("R4", err_cnt - e0, 1, "fall timeout error pulse");
    chk("R4", cs_pulses - s0, 0, "no read after fall timeout");
    repeat (250) @(negedge clk);
    chk("R4", cs_pulses - s0, 0, "late busy fall not taken as end");
    chk("R4", valid_cnt - v0, 0, "no valid after fall timeout");
    conv_len = 20;
  endtask

  initial begin
    test_reset();
    test_dummy();
    test_normal(12'hFFF, 1);
    test_normal(12'h001, 1);
    test_normal(12'h8A4, 8);
    test_ignore();
    test_rise_timeout();
    test_fall_timeout();
    test_normal(12'h7C2, 2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule